// File: doc/BRIEF.md
# Segmented Accumulator Port and Preload Controller

This block sits between a 35-bit accumulator register and three bidirectional pin groups. The groups are a 3-bit extension segment (accumulator bits 34:32), a 16-bit high segment (bits 31:16) and a 16-bit low segment (bits 15:0). The low segment's pins also carry the 16-bit Y operand into the multiplier. Tri-state pins are modelled as separate `*_pin_out`, `*_pin_oe` and `*_pin_in` signals.

A preload-mode input and three active-low segment enables select one of three states for each segment:
- drive the accumulator slice onto the pins,
- float the pins, or
- capture the pin data into that slice.

The block decodes the drive enables combinationally. It forms a 35-bit preload word and a per-segment preload strobe. It also holds the accumulator register itself. On every capture-enabled clock edge the register takes either the sum from the arithmetic core or, in preload mode, the pin data for the segments that are selected. Segments that are not selected keep their slice. The arithmetic core is outside this block.

Top module: `acc_port_ctrl`

## Requirements
- R1: When `prel`=0 and a segment's enable is 0, that segment's `*_pin_oe` is 1 and its `*_pin_out` equals its accumulator slice: extension = `acc_q[34:32]`, high = `acc_q[31:16]`, low = `acc_q[15:0]`.
- R2: When `prel`=0 and a segment's enable is 1, that segment's `*_pin_oe` is 0 and its `pre_strobe` bit is 0. The strobe bits are ordered [2]=extension, [1]=high, [0]=low.
- R3: When `prel`=1, all three `*_pin_oe` outputs are 0, whatever the enables are.
- R4: When `prel`=1, `cap_en`=1 and a segment's enable is 1, its `pre_strobe` bit is 1. The same clock edge loads that segment's pin data into its accumulator slice.
- R5: When `prel`=1 and a segment's enable is 0, that segment is neither driven nor strobed. Its accumulator slice holds its value across a capture edge.
- R6: When `prel`=0 and `cap_en`=1, the whole accumulator takes `sum_in` on the clock edge.
- R7: `y_data` always equals `lsp_pin_in`. `y_ok` is 1 exactly when the low segment's enable is 1.
- R8: After reset the accumulator is zero.
- R9: When `cap_en`=0, all `pre_strobe` bits are 0 and the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Product-capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prel | input | 1 | Preload mode |
| oe_xtp_n | input | 1 | Extension segment enable, active low |
| oe_msp_n | input | 1 | High segment enable, active low |
| oe_lsp_n | input | 1 | Low segment enable, active low |
| cap_en | input | 1 | Product-capture enable for this edge |
| sum_in | input | 35 | Next accumulator value from the arithmetic core |
| xtp_pin_in | input | 3 | Extension pin input |
| msp_pin_in | input | 16 | High pin input |
| lsp_pin_in | input | 16 | Low / Y shared pin input |
| xtp_pin_out | output | 3 | Extension pin drive data |
| xtp_pin_oe | output | 1 | Extension pin driver enable |
| msp_pin_out | output | 16 | High pin drive data |
| msp_pin_oe | output | 1 | High pin driver enable |
| lsp_pin_out | output | 16 | Low pin drive data |
| lsp_pin_oe | output | 1 | Low pin driver enable |
| y_data | output | 16 | Y operand routed from the shared pins |
| y_ok | output | 1 | Y operand accepted (low segment floating) |
| pre_word | output | 35 | Preload word assembled from the pins |
| pre_strobe | output | 3 | Per-segment preload write mask for this edge |
| acc_q | output | 35 | Accumulator contents |

## Verification
The bench builds the block with its default widths (3, 16 and 16 bits). This makes the whole control space small: preload mode and three enables give 16 combinations.

For every combination the bench does the following:
- It seeds the accumulator through the sum path with a distinct value.
- It checks each segment's drive, float and strobe decode, with the expected values worked out arithmetically.
- It checks the accumulator after the capture edge, slice by slice, against a merge of pin data and seed.

Separate steps cover reset and capture with `cap_en` low.

// File: rtl/acc_port_pkg.sv
package acc_port_pkg;

  // Segment index order used for enable and strobe vectors.
  typedef enum logic [1:0] {
    SEG_LO  = 2'd0,
    SEG_HI  = 2'd1,
    SEG_EXT = 2'd2
  } seg_idx_e;

  localparam int NSEG = 3;

  // Segment drives its slice: normal mode with its enable asserted (low).
  function automatic logic seg_drives(input logic prel, input logic en_n);
    return !prel && !en_n;
  endfunction

  // Segment takes pin data: preload mode with its enable released (high).
  function automatic logic seg_loads(input logic prel, input logic en_n);
    return prel && en_n;
  endfunction

  // Segment index that owns accumulator bit b.
  function automatic int seg_of_bit(input int b, input int lo_w, input int hi_w);
    if (b < lo_w) return int'(SEG_LO);
    else if (b < lo_w + hi_w) return int'(SEG_HI);
    else return int'(SEG_EXT);
  endfunction

endpackage

// File: rtl/acc_seg_ctrl.sv
module acc_seg_ctrl
  import acc_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic prel,
  input  logic en_n,
  input  logic cap_en,
  output logic drv,
  output logic sel,
  output logic strobe
);

  assign drv    = seg_drives(prel, en_n);
  assign sel    = seg_loads(prel, en_n);
  assign strobe = sel && cap_en;

  p_no_drive_in_preload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prel |-> !drv);

  p_drive_sel_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv && strobe));

  p_strobe_needs_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> !strobe);

endmodule

// File: rtl/acc_slice_reg.sv
module acc_slice_reg
  import acc_port_pkg::*;
#(
  parameter int LO_W  = 16,
  parameter int HI_W  = 16,
  parameter int EXT_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap_en,
  input  logic                          prel,
  input  logic [NSEG-1:0]               seg_sel,
  input  logic [LO_W+HI_W+EXT_W-1:0]    sum_in,
  input  logic [LO_W+HI_W+EXT_W-1:0]    pre_word,
  output logic [LO_W+HI_W+EXT_W-1:0]    acc_q
);

  localparam int AW = LO_W + HI_W + EXT_W;

  logic [AW-1:0] bit_wmask;
  logic [AW-1:0] acc_d;

  // Expand the per-segment mask to a per-bit write mask.
  for (genvar b = 0; b < AW; b++) begin : g_mask
    localparam int SEG = seg_of_bit(b, LO_W, HI_W);
    assign bit_wmask[b] = seg_sel[SEG];
  end

  always_comb begin
    acc_d = acc_q;
    if (cap_en) begin
      if (!prel) acc_d = sum_in;
      else       acc_d = (pre_word & bit_wmask) | (acc_q & ~bit_wmask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  p_sum_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !prel) |=> acc_q == $past(sum_in));

  p_hold_no_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(acc_q));

endmodule

// File: rtl/acc_port_ctrl.sv
module acc_port_ctrl
  import acc_port_pkg::*;
#(
  parameter int LO_W  = 16,
  parameter int HI_W  = 16,
  parameter int EXT_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       prel,
  input  logic                       oe_xtp_n,
  input  logic                       oe_msp_n,
  input  logic                       oe_lsp_n,
  input  logic                       cap_en,
  input  logic [LO_W+HI_W+EXT_W-1:0] sum_in,
  input  logic [EXT_W-1:0]           xtp_pin_in,
  input  logic [HI_W-1:0]            msp_pin_in,
  input  logic [LO_W-1:0]            lsp_pin_in,
  output logic [EXT_W-1:0]           xtp_pin_out,
  output logic                       xtp_pin_oe,
  output logic [HI_W-1:0]            msp_pin_out,
  output logic                       msp_pin_oe,
  output logic [LO_W-1:0]            lsp_pin_out,
  output logic                       lsp_pin_oe,
  output logic [LO_W-1:0]            y_data,
  output logic                       y_ok,
  output logic [LO_W+HI_W+EXT_W-1:0] pre_word,
  output logic [NSEG-1:0]            pre_strobe,
  output logic [LO_W+HI_W+EXT_W-1:0] acc_q
);

  localparam int AW     = LO_W + HI_W + EXT_W;
  localparam int HI_LSB = LO_W;
  localparam int EX_LSB = LO_W + HI_W;

  logic [NSEG-1:0] seg_en_n;
  logic [NSEG-1:0] seg_drv;
  logic [NSEG-1:0] seg_sel;

  assign seg_en_n = {oe_xtp_n, oe_msp_n, oe_lsp_n};

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    acc_seg_ctrl u_seg (
      .clk    (clk),
      .rst_n  (rst_n),
      .prel   (prel),
      .en_n   (seg_en_n[s]),
      .cap_en (cap_en),
      .drv    (seg_drv[s]),
      .sel    (seg_sel[s]),
      .strobe (pre_strobe[s])
    );
  end

  assign pre_word = {xtp_pin_in, msp_pin_in, lsp_pin_in};

  acc_slice_reg #(.LO_W(LO_W), .HI_W(HI_W), .EXT_W(EXT_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .prel     (prel),
    .seg_sel  (seg_sel),
    .sum_in   (sum_in),
    .pre_word (pre_word),
    .acc_q    (acc_q)
  );

  assign xtp_pin_out = acc_q[AW-1:EX_LSB];
  assign msp_pin_out = acc_q[EX_LSB-1:HI_LSB];
  assign lsp_pin_out = acc_q[HI_LSB-1:0];
  assign xtp_pin_oe  = seg_drv[SEG_EXT];
  assign msp_pin_oe  = seg_drv[SEG_HI];
  assign lsp_pin_oe  = seg_drv[SEG_LO];

  assign y_data = lsp_pin_in;
  assign y_ok   = oe_lsp_n;

  p_preload_all_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prel |-> !(xtp_pin_oe || msp_pin_oe || lsp_pin_oe));

  p_y_only_when_floating_r7: assert property (@(posedge clk) disable iff (!rst_n)
    y_ok |-> !lsp_pin_oe);

  p_lo_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && prel && oe_lsp_n) |=> acc_q[HI_LSB-1:0] == $past(lsp_pin_in));

  p_hi_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && prel && oe_msp_n) |=> acc_q[EX_LSB-1:HI_LSB] == $past(msp_pin_in));

  p_ext_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prel && !oe_xtp_n) |=> $stable(acc_q[AW-1:EX_LSB]));

  p_lo_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prel && !oe_lsp_n) |=> $stable(acc_q[HI_LSB-1:0]));

endmodule

// File: tb/acc_port_ctrl_tb.sv
module acc_port_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prel = 1'b0;
  logic        oe_xtp_n = 1'b1, oe_msp_n = 1'b1, oe_lsp_n = 1'b1;
  logic        cap_en = 1'b0;
  logic [34:0] sum_in = '0;
  logic [2:0]  xtp_pin_in = '0;
  logic [15:0] msp_pin_in = '0, lsp_pin_in = '0;
  logic [2:0]  xtp_pin_out;
  logic        xtp_pin_oe, msp_pin_oe, lsp_pin_oe;
  logic [15:0] msp_pin_out, lsp_pin_out, y_data;
  logic        y_ok;
  logic [34:0] pre_word, acc_q;
  logic [2:0]  pre_strobe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .prel(prel),
    .oe_xtp_n(oe_xtp_n), .oe_msp_n(oe_msp_n), .oe_lsp_n(oe_lsp_n),
    .cap_en(cap_en), .sum_in(sum_in),
    .xtp_pin_in(xtp_pin_in), .msp_pin_in(msp_pin_in), .lsp_pin_in(lsp_pin_in),
    .xtp_pin_out(xtp_pin_out), .xtp_pin_oe(xtp_pin_oe),
    .msp_pin_out(msp_pin_out), .msp_pin_oe(msp_pin_oe),
    .lsp_pin_out(lsp_pin_out), .lsp_pin_oe(lsp_pin_oe),
    .y_data(y_data), .y_ok(y_ok), .pre_word(pre_word),
    .pre_strobe(pre_strobe), .acc_q(acc_q)
  );

  task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [34:0] seed, exp_acc, held;
    // R8: reset state, observed with all segments driving
    prel = 1'b0; oe_xtp_n = 1'b0; oe_msp_n = 1'b0; oe_lsp_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 acc after reset", acc_q, 35'd0);
    chk("R8 low pins after reset", 35'(lsp_pin_out), 35'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int c = 0; c < 16; c++) begin
      logic p, ex, hi, lo;
      logic [2:0]  xp;
      logic [15:0] hp, lp;
      p  = c[3]; ex = c[2]; hi = c[1]; lo = c[0];
      seed = 35'h29C3E5A17 ^ {c[2:0], {8{c[3:0]}}};
      xp = 3'(c) ^ 3'b101;
      hp = 16'hC3A0 + 16'(c * 7);
      lp = 16'h0F5E ^ 16'(c * 257);

      // Seed the accumulator through the sum path.
      @(negedge clk);
      prel = 1'b0; oe_xtp_n = 1'b1; oe_msp_n = 1'b1; oe_lsp_n = 1'b1;
      cap_en = 1'b1; sum_in = seed;
      @(negedge clk);
      #1;
      chk($sformatf("R6 sum capture c=%0d", c), acc_q, seed);

      // Apply this control combination.
      prel = p; oe_xtp_n = ex; oe_msp_n = hi; oe_lsp_n = lo;
      xtp_pin_in = xp; msp_pin_in = hp; lsp_pin_in = lp;
      sum_in = ~seed;
      #1;
      chk($sformatf("R1/R2/R3 ext oe c=%0d", c), 35'(xtp_pin_oe), 35'(!p && !ex));
      chk($sformatf("R1/R2/R3 hi oe c=%0d", c),  35'(msp_pin_oe), 35'(!p && !hi));
      chk($sformatf("R1/R2/R3 lo oe c=%0d", c),  35'(lsp_pin_oe), 35'(!p && !lo));
      if (!p && !ex) chk($sformatf("R1 ext data c=%0d", c), 35'(xtp_pin_out), 35'(seed[34:32]));
      if (!p && !hi) chk($sformatf("R1 hi data c=%0d", c),  35'(msp_pin_out), 35'(seed[31:16]));
      if (!p && !lo) chk($sformatf("R1 lo data c=%0d", c),  35'(lsp_pin_out), 35'(seed[15:0]));
      chk($sformatf("R2/R4/R5 strobe c=%0d", c), 35'(pre_strobe),
          35'({p && ex, p && hi, p && lo}));
      chk($sformatf("R7 y_ok c=%0d", c), 35'(y_ok), 35'(lo));
      chk($sformatf("R7 y_data c=%0d", c), 35'(y_data), 35'(lp));
      chk($sformatf("R4 pre_word c=%0d", c), pre_word, {xp, hp, lp});

      if (p) exp_acc = {ex ? xp : seed[34:32], hi ? hp : seed[31:16], lo ? lp : seed[15:0]};
      else   exp_acc = ~seed;
      @(negedge clk);
      #1;
      chk($sformatf("R4/R5/R6 acc after edge c=%0d", c), acc_q, exp_acc);
      cap_en = 1'b0;
    end

    // R9: preload requested but capture disabled.
    @(negedge clk);
    held = acc_q;
    prel = 1'b1; oe_xtp_n = 1'b1; oe_msp_n = 1'b1; oe_lsp_n = 1'b1;
    cap_en = 1'b0; xtp_pin_in = ~held[34:32]; msp_pin_in = ~held[31:16]; lsp_pin_in = ~held[15:0];
    #1;
    chk("R9 strobe without capture", 35'(pre_strobe), 35'd0);
    @(negedge clk);
    #1;
    chk("R9 acc held without capture", acc_q, held);
    prel = 1'b0; sum_in = 35'h7_FFFF_FFFF;
    @(negedge clk);
    #1;
    chk("R9 sum ignored without capture", acc_q, held);

    done = 1;
    finish_run();
  end

endmodule